// File: doc/BRIEF.md
# I2C Master Bit-Level Byte Engine

This block is the bit-level engine of an I2C bus master. It drives the clock and data lines as open-drain signals: each output is a pull-low enable, so a line is either released or pulled low and is never driven high. Both lines are read back through two-flop synchronizers. A controller hands the engine one command at a time: produce a START condition, send a byte, receive a byte, or produce a STOP condition. Each command ends with a one-cycle response that reports success or failure. A byte send also reports whether the slave acknowledged.

Every step is timed in quarter-bit periods, counted in system clock cycles from a static input. Each time the engine releases the clock line, it waits until the line actually reads high, which lets a slave stretch the clock. The wait is bounded by a poll limit taken from a second static input. A START retries while the data line is held low. A STOP is confirmed only when the data line is read back high. Both timing inputs are captured when a command is accepted. A controller builds transfers from these commands, for example START, address byte, data bytes, STOP, or a repeated START between a send and a receive.

Top module: `i2cb_engine`

## Requirements
- R1: After reset, both pull-low enables are 0 (lines released), `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both 1. From then on `cmd_ready` stays 0 until the response. The response is a `rsp_valid` pulse of exactly one cycle.
- R3: The `cmd_op` encoding is 0 = START, 1 = byte write, 2 = byte read, 3 = STOP. The outputs only ever request a line to be pulled low.
- R4: START releases both lines and then samples the data line once per quarter period. If the data line reads low on START_TRIES consecutive samples, the command fails. Otherwise the engine waits for the clock line high, pulls data low, waits a quarter, pulls clock low and waits a quarter. A successful START ends with both enables at 1.
- R5: A byte write sends `wr_byte` MSB first. The data enable changes only while the clock line is pulled low. In the ninth clock the engine releases data and samples it: low gives `rsp_ack` = 1, high gives `rsp_ack` = 0.
- R6: A byte read gathers 8 bits MSB first into `rd_byte`, sampling data once the clock reads high. In the ninth clock the engine pulls data low when `rd_last` = 0 and leaves it released when `rd_last` = 1.
- R7: STOP pulls clock low, pulls data low, releases clock and waits for it high, then releases data. It then polls data up to 3 times, a quarter apart. It succeeds with both enables at 0, and fails if data never reads high.
- R8: After each clock release the engine waits one quarter and then polls the clock once per quarter. The command fails once `stretch_limit` + 1 polls have all read low, so raising the limit by N lengthens a failing command by exactly N quarters.
- R9: All waits are whole quarters of `quarter_cnt` cycles (minimum 4). A START on an idle bus lasts 4·Q + 1 cycles from acceptance to response, so it scales by 4 cycles per unit of Q.
- R10: `quarter_cnt` and `stretch_limit` are captured at acceptance. Changing them during a command has no effect on that command.
- R11: `rsp_ack` is 1 only for a successful byte write that was acknowledged. For every other command it is 0. `rsp_ok` is 0 on any failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| quarter_cnt | input | QW | Quarter-bit period in clock cycles (>= 4) |
| stretch_limit | input | TW | Clock-high poll limit; the command fails after this plus one low polls |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle and able to accept a command |
| cmd_op | input | 2 | 0 START, 1 write byte, 2 read byte, 3 STOP |
| wr_byte | input | 8 | Byte to send |
| rd_last | input | 1 | Read is the last byte (answer with NACK) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Command completed without fault |
| rsp_ack | output | 1 | Slave acknowledged the written byte |
| rd_byte | output | 8 | Byte gathered by the last successful read |
| scl_in | input | 1 | Clock line level as seen on the bus |
| sda_in | input | 1 | Data line level as seen on the bus |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |

## Verification
The assertions assume that `quarter_cnt` is at least 4 at acceptance, so the two-cycle synchronizer delay fits inside one quarter. They also assume that `cmd_valid` is raised only while the engine is idle. The bench programs quarter values of 4, 10 and 20 and issues each command only after the previous response. The bench's slave model changes the data line only on a falling clock edge and holds the clock or data low only for stretch and stuck-line cases, so the data-stable-while-clock-high property reflects the engine alone.

// File: rtl/i2cb_pkg.sv
// Package: shared encodings for the I2C bit engine.
// Assumes nothing; holds the command code and sequencer state types.
package i2cb_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } i2cb_op_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_HIWAIT,
        S_ST_CHK,
        S_ST_SDA,
        S_ST_SCL,
        S_ST_END,
        S_WB_SET,
        S_WB_RISE,
        S_WB_HIGH,
        S_WB_HOLD,
        S_WB_TAIL,
        S_RB_RISE,
        S_RB_HIGH,
        S_RB_GAP,
        S_RA_SET,
        S_RA_RISE,
        S_RA_HIGH,
        S_RA_DROP,
        S_RA_TAIL,
        S_SP_SDA,
        S_SP_REL,
        S_SP_FREE,
        S_SP_POLL
    } i2cb_st_e;

endpackage

// File: rtl/i2cb_sync.sv
// Module: i2cb_sync
// Two-flop synchronizer for each of W asynchronous line inputs.
// Assumes idle lines read high, so both stages reset to 1.
module i2cb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar g;
    for (g = 0; g < W; g++) begin : g_line
        logic stage1;
        logic stage2;
        // Two-stage capture of one line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1 <= 1'b1;
                stage2 <= 1'b1;
            end else begin
                stage1 <= d[g];
                stage2 <= stage1;
            end
        end
        assign q[g] = stage2;
    end
endmodule

// File: rtl/i2cb_qtimer.sv
// Module: i2cb_qtimer
// Counts one or two quarter periods while run is high and pulses tick in
// the last cycle of the span, then restarts. Dropping run clears the count.
// Assumes qlen >= 1.
module i2cb_qtimer #(
    parameter int QW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          span2,
    input  logic [QW-1:0] qlen,
    output logic          tick
);
    localparam int CW = QW + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] end_val;

    // Final count of the current span.
    always_comb begin
        if (span2) end_val = {qlen, 1'b0} - CW'(1);
        else       end_val = {1'b0, qlen} - CW'(1);
    end

    assign tick = run && (cnt == end_val);

    // Cycle counter, cleared when idle or at the end of a span.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/i2cb_seq.sv
// Module: i2cb_seq
// Command sequencer: steps through START, byte write, byte read and STOP
// one quarter period at a time, with clock-stretch polling and START retry.
// Assumes synchronized line inputs and a quarter of at least 4 cycles.
module i2cb_seq
    import i2cb_pkg::*;
#(
    parameter int QW           = 12,
    parameter int TW           = 12,
    parameter int START_TRIES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [7:0]    wr_byte,
    input  logic          rd_last,
    input  logic [QW-1:0] quarter_cnt,
    input  logic [TW-1:0] stretch_limit,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          tick,
    output logic          cmd_ready,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic          rsp_ack,
    output logic [7:0]    rd_byte,
    output logic          t_run,
    output logic          t_span2,
    output logic [QW-1:0] q_len,
    output logic          scl_oe,
    output logic          sda_oe
);
    localparam int RW = (START_TRIES > 1) ? $clog2(START_TRIES) : 1;
    localparam logic [RW-1:0] TRY_LAST = RW'(START_TRIES - 1);

    i2cb_st_e      state;
    i2cb_st_e      ret;
    logic [TW-1:0] lim;
    logic [TW-1:0] polls;
    logic [RW-1:0] tries;
    logic [3:0]    bitn;
    logic [7:0]    sh;
    logic          last_q;
    logic          ack_q;
    logic [1:0]    sp_polls;

    assign cmd_ready = (state == S_IDLE);

    // Which states spend time, and which span two quarters.
    always_comb begin
        unique case (state)
            S_HIWAIT, S_ST_CHK, S_ST_SCL, S_ST_END, S_WB_SET, S_WB_RISE,
            S_WB_HOLD, S_WB_TAIL, S_RB_GAP, S_RA_SET, S_RA_RISE, S_RA_DROP,
            S_RA_TAIL, S_SP_SDA, S_SP_REL, S_SP_POLL: t_run = 1'b1;
            default:                                  t_run = 1'b0;
        endcase
        t_span2 = (state == S_WB_HOLD) || (state == S_WB_TAIL) || (state == S_RB_GAP);
    end

    // Main sequencer: line enables, byte shifting and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            ret       <= S_IDLE;
            q_len     <= QW'(4);
            lim       <= '0;
            polls     <= '0;
            tries     <= '0;
            bitn      <= '0;
            sh        <= '0;
            last_q    <= 1'b0;
            ack_q     <= 1'b0;
            sp_polls  <= '0;
            scl_oe    <= 1'b0;
            sda_oe    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_ack   <= 1'b0;
            rd_byte   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        q_len   <= quarter_cnt;
                        lim     <= stretch_limit;
                        sh      <= wr_byte;
                        last_q  <= rd_last;
                        bitn    <= '0;
                        tries   <= '0;
                        ack_q   <= 1'b0;
                        rsp_ack <= 1'b0;
                        unique case (i2cb_op_e'(cmd_op))
                            OP_START: begin
                                scl_oe <= 1'b0;
                                sda_oe <= 1'b0;
                                state  <= S_ST_CHK;
                            end
                            OP_WRITE: state <= S_WB_SET;
                            OP_READ: begin
                                sda_oe <= 1'b0;
                                state  <= S_RB_RISE;
                            end
                            default: begin
                                scl_oe <= 1'b1;
                                state  <= S_SP_SDA;
                            end
                        endcase
                    end
                end
                // Clock release: poll once per quarter until it reads high.
                S_HIWAIT: begin
                    if (tick) begin
                        if (scl_s) begin
                            state <= ret;
                        end else if (polls == lim) begin
                            rsp_valid <= 1'b1;
                            rsp_ok    <= 1'b0;
                            state     <= S_IDLE;
                        end else begin
                            polls <= polls + TW'(1);
                        end
                    end
                end
                // START: data must read high before the condition is made.
                S_ST_CHK: begin
                    if (tick) begin
                        if (sda_s) begin
                            polls <= '0;
                            ret   <= S_ST_SDA;
                            state <= S_HIWAIT;
                        end else if (tries == TRY_LAST) begin
                            rsp_valid <= 1'b1;
                            rsp_ok    <= 1'b0;
                            state     <= S_IDLE;
                        end else begin
                            tries <= tries + RW'(1);
                        end
                    end
                end
                S_ST_SDA: begin
                    sda_oe <= 1'b1;
                    state  <= S_ST_SCL;
                end
                S_ST_SCL: begin
                    if (tick) begin
                        scl_oe <= 1'b1;
                        state  <= S_ST_END;
                    end
                end
                S_ST_END: begin
                    if (tick) begin
                        rsp_valid <= 1'b1;
                        rsp_ok    <= 1'b1;
                        state     <= S_IDLE;
                    end
                end
                // Byte write: eight data bits, then the acknowledge slot.
                S_WB_SET: begin
                    if (tick) begin
                        sda_oe <= (bitn == 4'd8) ? 1'b0 : ~sh[7];
                        state  <= S_WB_RISE;
                    end
                end
                S_WB_RISE: begin
                    if (tick) begin
                        scl_oe <= 1'b0;
                        polls  <= '0;
                        ret    <= S_WB_HIGH;
                        state  <= S_HIWAIT;
                    end
                end
                S_WB_HIGH: begin
                    if (bitn == 4'd8) begin
                        ack_q <= ~sda_s;
                        state <= S_WB_HOLD;
                    end else begin
                        scl_oe <= 1'b1;
                        sh     <= {sh[6:0], 1'b0};
                        bitn   <= bitn + 4'd1;
                        state  <= S_WB_SET;
                    end
                end
                S_WB_HOLD: begin
                    if (tick) begin
                        scl_oe <= 1'b1;
                        state  <= S_WB_TAIL;
                    end
                end
                S_WB_TAIL: begin
                    if (tick) begin
                        rsp_valid <= 1'b1;
                        rsp_ok    <= 1'b1;
                        rsp_ack   <= ack_q;
                        state     <= S_IDLE;
                    end
                end
                // Byte read: eight sampled bits, then the master answer.
                S_RB_RISE: begin
                    scl_oe <= 1'b0;
                    polls  <= '0;
                    ret    <= S_RB_HIGH;
                    state  <= S_HIWAIT;
                end
                S_RB_HIGH: begin
                    sh     <= {sh[6:0], sda_s};
                    scl_oe <= 1'b1;
                    state  <= S_RB_GAP;
                end
                S_RB_GAP: begin
                    if (tick) begin
                        if (bitn == 4'd7) begin
                            state <= S_RA_SET;
                        end else begin
                            bitn  <= bitn + 4'd1;
                            state <= S_RB_RISE;
                        end
                    end
                end
                S_RA_SET: begin
                    if (tick) begin
                        sda_oe <= ~last_q;
                        state  <= S_RA_RISE;
                    end
                end
                S_RA_RISE: begin
                    if (tick) begin
                        scl_oe <= 1'b0;
                        polls  <= '0;
                        ret    <= S_RA_HIGH;
                        state  <= S_HIWAIT;
                    end
                end
                S_RA_HIGH: begin
                    scl_oe <= 1'b1;
                    state  <= S_RA_DROP;
                end
                S_RA_DROP: begin
                    if (tick) begin
                        sda_oe <= 1'b0;
                        state  <= S_RA_TAIL;
                    end
                end
                S_RA_TAIL: begin
                    if (tick) begin
                        rd_byte   <= sh;
                        rsp_valid <= 1'b1;
                        rsp_ok    <= 1'b1;
                        state     <= S_IDLE;
                    end
                end
                // STOP: data low under low clock, clock up, then data up.
                S_SP_SDA: begin
                    if (tick) begin
                        sda_oe <= 1'b1;
                        state  <= S_SP_REL;
                    end
                end
                S_SP_REL: begin
                    if (tick) begin
                        scl_oe <= 1'b0;
                        polls  <= '0;
                        ret    <= S_SP_FREE;
                        state  <= S_HIWAIT;
                    end
                end
                S_SP_FREE: begin
                    sda_oe   <= 1'b0;
                    sp_polls <= '0;
                    state    <= S_SP_POLL;
                end
                S_SP_POLL: begin
                    if (tick) begin
                        if (sda_s) begin
                            rsp_valid <= 1'b1;
                            rsp_ok    <= 1'b1;
                            state     <= S_IDLE;
                        end else if (sp_polls == 2'd2) begin
                            rsp_valid <= 1'b1;
                            rsp_ok    <= 1'b0;
                            state     <= S_IDLE;
                        end else begin
                            sp_polls <= sp_polls + 2'd1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cb_engine.sv
// Module: i2cb_engine (top)
// I2C master bit engine: synchronizes the two bus lines, times every step
// in quarter periods and sequences one command at a time.
// Assumes quarter_cnt >= 4 and cmd_valid only raised while cmd_ready is 1.
module i2cb_engine #(
    parameter int QW          = 12,
    parameter int TW          = 12,
    parameter int START_TRIES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [QW-1:0] quarter_cnt,
    input  logic [TW-1:0] stretch_limit,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [7:0]    wr_byte,
    input  logic          rd_last,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic          rsp_ack,
    output logic [7:0]    rd_byte,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe
);
    logic [1:0]    lines_s;
    logic          tick;
    logic          t_run;
    logic          t_span2;
    logic [QW-1:0] q_len;

    i2cb_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sda_in, scl_in}),
        .q     (lines_s)
    );

    i2cb_qtimer #(.QW(QW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (t_run),
        .span2 (t_span2),
        .qlen  (q_len),
        .tick  (tick)
    );

    i2cb_seq #(.QW(QW), .TW(TW), .START_TRIES(START_TRIES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .wr_byte       (wr_byte),
        .rd_last       (rd_last),
        .quarter_cnt   (quarter_cnt),
        .stretch_limit (stretch_limit),
        .scl_s         (lines_s[0]),
        .sda_s         (lines_s[1]),
        .tick          (tick),
        .cmd_ready     (cmd_ready),
        .rsp_valid     (rsp_valid),
        .rsp_ok        (rsp_ok),
        .rsp_ack       (rsp_ack),
        .rd_byte       (rd_byte),
        .t_run         (t_run),
        .t_span2       (t_span2),
        .q_len         (q_len),
        .scl_oe        (scl_oe),
        .sda_oe        (sda_oe)
    );
endmodule

// File: rtl/i2cb_engine_chk.sv
// Module: i2cb_engine_chk
// Protocol checker for i2cb_engine, attached by bind below.
// Assumes the environment keeps quarter_cnt >= 4 at acceptance.
module i2cb_engine_chk #(
    parameter int QW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [1:0]    cmd_op,
    input logic [QW-1:0] quarter_cnt,
    input logic          rsp_valid,
    input logic          rsp_ok,
    input logic          rsp_ack,
    input logic          scl_oe,
    input logic          sda_oe
);
    logic [1:0] cur_op;
    logic       busy;
    logic       acc;

    assign acc = cmd_valid && cmd_ready;

    // Track the command in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op <= 2'd0;
            busy   <= 1'b0;
        end else begin
            if (acc) cur_op <= cmd_op;
            if (acc)            busy <= 1'b1;
            else if (rsp_valid) busy <= 1'b0;
        end
    end

    AST_QTR_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (quarter_cnt >= QW'(4)));                               // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !cmd_ready);                                            // R2
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                      // R2
    AST_RSP_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);                                            // R2
    AST_ACK_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ack) |-> (rsp_ok && cur_op == 2'd1));         // R11
    AST_START_LEAVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && cur_op == 2'd0) |-> (scl_oe && sda_oe)); // R4
    AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && cur_op == 2'd3) |-> (!scl_oe && !sda_oe)); // R7
    AST_SDA_STABLE_SCL_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && $past(!cmd_ready) && (cur_op == 2'd1 || cur_op == 2'd2)
         && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));             // R5
endmodule

bind i2cb_engine i2cb_engine_chk #(.QW(QW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .quarter_cnt (quarter_cnt),
    .rsp_valid   (rsp_valid),
    .rsp_ok      (rsp_ok),
    .rsp_ack     (rsp_ack),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe)
);

// File: tb/i2cb_engine_bench.sv
`timescale 1ns/1ps
// Bench for i2cb_engine: a table of command vectors against a small slave
// model, then directed timing, stretch, retry and stuck-line cases.
module i2cb_engine_bench;
    localparam int QW = 12;
    localparam int TW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [QW-1:0] quarter_cnt = QW'(4);
    logic [TW-1:0] stretch_limit = TW'(20);
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic [7:0]    wr_byte = 8'h00;
    logic          rd_last = 1'b0;
    logic          rsp_valid, rsp_ok, rsp_ack;
    logic [7:0]    rd_byte;
    logic          scl_oe, sda_oe;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // Slave model state.
    int         mode = 0;          // 0 none, 1 write target, 2 read source
    logic [7:0] slv_byte = 8'h00;
    logic       slv_ack = 1'b0;
    int         scl_until = 0;     // clock held low while cyc < scl_until
    int         sda_until = 0;     // data held low while cyc < sda_until
    int         fcnt = 0, fall_base = 0;
    int         rcnt = 0;
    logic [8:0] cap_all = '0;
    logic       slv_sda_low;

    wire scl_line = !scl_oe && !(cyc < scl_until);
    wire sda_line = !sda_oe && !slv_sda_low && !(cyc < sda_until);

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        int f;
        f = fcnt - fall_base;
        slv_sda_low = 1'b0;
        if (mode == 2 && f >= 0 && f < 8) slv_sda_low = !slv_byte[7 - f];
        if (mode == 1 && f == 8)          slv_sda_low = slv_ack;
    end

    always @(negedge scl_line) fcnt = fcnt + 1;
    always @(posedge scl_line) begin
        cap_all = {cap_all[7:0], sda_line};
        rcnt = rcnt + 1;
    end

    i2cb_engine #(.QW(QW), .TW(TW), .START_TRIES(4)) u_i2cb_engine (
        .clk(clk), .rst_n(rst_n), .quarter_cnt(quarter_cnt),
        .stretch_limit(stretch_limit), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .wr_byte(wr_byte),
        .rd_last(rd_last), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_ack(rsp_ack), .rd_byte(rd_byte), .scl_in(scl_line),
        .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic check(input logic cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Result of the last command.
    logic r_ok, r_ack;
    logic [7:0] r_rd;
    int r_cyc, r_rises;

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] wb, input logic last,
                           input int smode, input logic [7:0] sb, input logic sack,
                           input int altq);
        int rise_base;
        logic [QW-1:0] keep_q;
        @(negedge clk);
        mode = smode; slv_byte = sb; slv_ack = sack;
        fall_base = fcnt; rise_base = rcnt;
        cmd_op = op; wr_byte = wb; rd_last = last; cmd_valid = 1'b1;
        keep_q = quarter_cnt;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (altq != 0) quarter_cnt = QW'(altq);
        r_cyc = 0;
        while (!rsp_valid && r_cyc < 20000) begin
            @(negedge clk);
            r_cyc++;
        end
        check(rsp_valid, "R2 response seen", 0, 1);
        r_ok = rsp_ok; r_ack = rsp_ack; r_rd = rd_byte;
        r_rises = rcnt - rise_base;
        quarter_cnt = keep_q;
        mode = 0;
    endtask

    // Vector: op, write byte, last, slave byte, slave ack. Op codes per R3.
    localparam int NV = 11;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 8'h00, 1'b0, 8'h00, 1'b0},
        {2'd1, 8'hA0, 1'b0, 8'h00, 1'b1},
        {2'd1, 8'h5A, 1'b0, 8'h00, 1'b1},
        {2'd0, 8'h00, 1'b0, 8'h00, 1'b0},
        {2'd1, 8'hA1, 1'b0, 8'h00, 1'b1},
        {2'd2, 8'h00, 1'b0, 8'hC3, 1'b0},
        {2'd2, 8'h00, 1'b1, 8'h3C, 1'b0},
        {2'd3, 8'h00, 1'b0, 8'h00, 1'b0},
        {2'd0, 8'h00, 1'b0, 8'h00, 1'b0},
        {2'd1, 8'h77, 1'b0, 8'h00, 1'b0},
        {2'd3, 8'h00, 1'b0, 8'h00, 1'b0}
    };

    initial begin : watchdog
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int d4, d10, d2, d5;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(scl_oe == 1'b0, "R1 scl_oe", scl_oe, 0);
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] wb, sb;
            logic last, sack;
            {op, wb, last, sb, sack} = VEC[i];
            run_cmd(op, wb, last, (op == 2'd1) ? 1 : ((op == 2'd2) ? 2 : 0), sb, sack, 0);
            check(r_ok == 1'b1, "R3 command ok", r_ok, 1);
            check(r_ack == (op == 2'd1 && sack), "R11 rsp_ack", r_ack, (op == 2'd1 && sack));
            if (op == 2'd1) begin
                // R5: MSB first on the bus, then the slave's answer
                check(r_rises == 9, "R5 clock count", r_rises, 9);
                check(cap_all == {wb, !sack}, "R5 bus bits", cap_all, {wb, !sack});
            end
            if (op == 2'd2) begin
                // R6: gathered byte and master answer bit
                check(r_rd == sb, "R6 rd_byte", r_rd, sb);
                check(cap_all == {sb, last}, "R6 bus bits", cap_all, {sb, last});
            end
            if (op == 2'd0) check(scl_oe && sda_oe, "R4 start leaves lines low", {scl_oe, sda_oe}, 3);
            if (op == 2'd3) check(!scl_oe && !sda_oe && scl_line && sda_line,
                                  "R7 stop frees lines", {scl_oe, sda_oe}, 0);
        end

        // R9: START duration scales by 4 cycles per quarter unit
        quarter_cnt = QW'(10);
        run_cmd(2'd0, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0); d10 = r_cyc;
        run_cmd(2'd3, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);
        quarter_cnt = QW'(4);
        run_cmd(2'd0, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0); d4 = r_cyc;
        run_cmd(2'd3, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);
        check(d10 - d4 == 24, "R9 start scaling", d10 - d4, 24);

        // R10: quarter change after acceptance has no effect
        run_cmd(2'd0, 8'h00, 1'b0, 0, 8'h00, 1'b0, 20);
        check(r_cyc == d4, "R10 captured quarter", r_cyc, d4);
        run_cmd(2'd3, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);

        // R8: short stretch inside the limit
        run_cmd(2'd0, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);
        scl_until = cyc + 30;
        run_cmd(2'd1, 8'hA0, 1'b0, 1, 8'h00, 1'b1, 0);
        check(r_ok && r_ack, "R8 stretched write", {r_ok, r_ack}, 3);
        run_cmd(2'd3, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);

        // R8: stuck clock fails after limit+1 polls
        run_cmd(2'd0, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);
        scl_until = 32'h7fffffff;
        stretch_limit = TW'(2);
        run_cmd(2'd1, 8'h55, 1'b0, 0, 8'h00, 1'b0, 0); d2 = r_cyc;
        check(r_ok == 1'b0, "R8 stuck clock fails", r_ok, 0);
        stretch_limit = TW'(5);
        run_cmd(2'd1, 8'h55, 1'b0, 0, 8'h00, 1'b0, 0); d5 = r_cyc;
        check(d5 - d2 == 12, "R8 poll limit timing", d5 - d2, 12);
        scl_until = 0;
        stretch_limit = TW'(20);
        run_cmd(2'd3, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);
        check(r_ok == 1'b1, "R7 recovery stop", r_ok, 1);

        // R4: data held low defeats START; brief hold is retried through
        sda_until = 32'h7fffffff;
        run_cmd(2'd0, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);
        check(r_ok == 1'b0, "R4 start retries exhausted", r_ok, 0);
        sda_until = cyc + 6;
        run_cmd(2'd0, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);
        check(r_ok == 1'b1, "R4 start after retry", r_ok, 1);

        // R7: STOP fails while data stays low, then succeeds
        sda_until = 32'h7fffffff;
        run_cmd(2'd3, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);
        check(r_ok == 1'b0, "R7 stop data stuck", r_ok, 0);
        sda_until = 0;
        run_cmd(2'd3, 8'h00, 1'b0, 0, 8'h00, 1'b0, 0);
        check(r_ok == 1'b1 && scl_line && sda_line, "R7 stop confirmed", r_ok, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule